// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block carries a PLL from one divider setting to another without letting a half-configured oscillator reach the logic it clocks. A single start pulse brings in a target PLL number and three divider values: reference divider, feedback multiplier and output divider. The block first checks that the request is legal. It rejects an output divider that is neither one nor even, a zero reference divider and an unknown PLL number. It also checks the VCO and output frequencies against their allowed windows. A rejected request changes no output and ends with a failure pulse.

For a legal request the block moves the PLL's output onto the reference-oscillator bypass and puts the PLL into reset. It then writes the divider fields, each encoded as the value minus one, together with a bandwidth field derived from the multiplier. Reset is held for a programmable settle time and then released. The block waits for the lock flag of the selected PLL, taken from a shared status word and synchronised, and only then switches the output back to normal and pulses done. If lock never arrives within a timeout window, the PLL stays on the bypass and a timeout failure is reported.

Several PLL instances may share one sequencer. The registered field outputs are meant to be steered to the PLL named on `tgt_id_o`.

Top module: `pll_update_seq`

## Requirements
- R1: After reset, mode_o is 0 (slow bypass), pll_rst_o is 0, every field output is 0, and busy_o, done_o and fail_o are 0.
- R2: A request whose output divider is neither 1 nor even is rejected. This includes an output divider of 0. Rejection is a one-cycle fail_o pulse with fail_why_o = 1.
- R3: A request whose VCO frequency REF_KHZ*NF/NR lies outside [VCO_MIN_KHZ, VCO_MAX_KHZ] is rejected (fail_why_o = 1). Both window edges count as legal.
- R4: A request whose output frequency VCO/NO lies outside [OUT_MIN_KHZ, OUT_MAX_KHZ] is rejected (fail_why_o = 1). Both window edges count as legal.
- R5: A request with NR = 0 or with a PLL number not below NUM_PLL is rejected (fail_why_o = 1).
- R6: A rejected request leaves mode_o, every field output and pll_rst_o unchanged, and never asserts pll_rst_o.
- R7: For a legal request, mode_o is 0 (slow) on every cycle in which pll_rst_o is 1. The mode encoding is 0 slow, 1 normal, 2 deep.
- R8: A legal request drives nr_fld_o = NR-1, nf_fld_o = NF-1, no_fld_o = NO-1 and bw_fld_o = (NF>>1)-1, each truncated to its field width. The fields change only while pll_rst_o is 1.
- R9: pll_rst_o stays 1 for at least SETTLE_CYC cycles, counting the cycle in which the fields take their new values, and is then released.
- R10: Lock is taken from lock_stat_i bit LOCK_BASE+id only; all other bits are ignored. mode_o becomes 1 (normal) together with a one-cycle done_o pulse, and only after that bit has been seen set.
- R11: If the selected lock bit stays low for TIMEOUT_CYC cycles after reset release, fail_o pulses with fail_why_o = 2, mode_o stays 0 and pll_rst_o is 0.
- R12: A start pulse while busy_o is 1 is ignored; the fields finally written are those of the request already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request strobe |
| pll_id_i | input | ID_W | Target PLL number |
| nr_i | input | NR_W | Reference divider value |
| nf_i | input | NF_W | Feedback multiplier value |
| no_i | input | NO_W | Output divider value |
| lock_stat_i | input | STAT_W | Shared status word holding lock flags |
| mode_o | output | 2 | Output mode: 0 slow, 1 normal, 2 deep |
| pll_rst_o | output | 1 | PLL reset |
| tgt_id_o | output | ID_W | PLL the outputs currently apply to |
| nr_fld_o | output | NR_W | Encoded reference divider field |
| nf_fld_o | output | NF_W | Encoded feedback divider field |
| no_fld_o | output | NO_W | Encoded output divider field |
| bw_fld_o | output | BW_W | Bandwidth-adjust field |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| fail_why_o | output | 2 | Failure reason: 1 illegal, 2 lock timeout |

## Verification
The bench builds the block with a 5-bit output divider instead of 4 bits, which makes the lower output-frequency limit reachable (NO of 16 and 18). It also uses a settle time of 6 cycles and a lock timeout of 40 cycles, so a full reprogramming cycle takes a few tens of clocks. That makes a near-exhaustive sweep over reference divider, multiplier and output divider affordable, and every legal/illegal boundary of the VCO and output windows is reached exactly. The status bits of all non-selected PLLs are held high, so a wrong lock-bit choice completes before lock.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
  typedef enum logic [1:0] {
    PM_SLOW   = 2'd0,
    PM_NORMAL = 2'd1,
    PM_DEEP   = 2'd2
  } pll_mode_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_ARM, S_LOAD, S_SETTLE, S_POLL
  } seq_state_e;

  localparam logic [1:0] WHY_NONE    = 2'd0;
  localparam logic [1:0] WHY_ILLEGAL = 2'd1;
  localparam logic [1:0] WHY_TIMEOUT = 2'd2;
endpackage

// File: rtl/pll_cfg_check.sv
module pll_cfg_check #(
  parameter int unsigned NR_W        = 6,
  parameter int unsigned NF_W        = 13,
  parameter int unsigned NO_W        = 4,
  parameter int unsigned ID_W        = 3,
  parameter int unsigned NUM_PLL     = 5,
  parameter int unsigned REF_KHZ     = 24000,
  parameter int unsigned VCO_MIN_KHZ = 440000,
  parameter int unsigned VCO_MAX_KHZ = 2200000,
  parameter int unsigned OUT_MIN_KHZ = 27500,
  parameter int unsigned OUT_MAX_KHZ = 2200000
) (
  input  logic [NR_W-1:0] nr,
  input  logic [NF_W-1:0] nf,
  input  logic [NO_W-1:0] no,
  input  logic [ID_W-1:0] id,
  output logic            legal
);
  localparam logic [63:0] REF64  = 64'(REF_KHZ);
  localparam logic [63:0] VLO64  = 64'(VCO_MIN_KHZ);
  localparam logic [63:0] VHI64  = 64'(VCO_MAX_KHZ);
  localparam logic [63:0] OLO64  = 64'(OUT_MIN_KHZ);
  localparam logic [63:0] OHI64  = 64'(OUT_MAX_KHZ);

  logic [63:0] vco_scaled;  // REF*NF, i.e. VCO times NR
  logic [63:0] nr_no;
  logic        no_ok, vco_ok, out_ok, misc_ok;

  always_comb begin
    vco_scaled = REF64 * 64'(nf);
    nr_no      = 64'(nr) * 64'(no);
    no_ok      = (no == NO_W'(1)) || ((no != '0) && !no[0]);
    vco_ok     = (vco_scaled >= VLO64 * 64'(nr)) && (vco_scaled <= VHI64 * 64'(nr));
    out_ok     = (vco_scaled >= OLO64 * nr_no) && (vco_scaled <= OHI64 * nr_no);
    misc_ok    = (nr != '0) && (32'(id) < NUM_PLL);
    legal      = no_ok && vco_ok && out_ok && misc_ok;
  end
endmodule

// File: rtl/pll_lock_pick.sv
module pll_lock_pick #(
  parameter int unsigned STAT_W    = 16,
  parameter int unsigned LOCK_BASE = 5,
  parameter int unsigned ID_W      = 3,
  parameter int unsigned SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat,
  input  logic [ID_W-1:0]   id,
  output logic              locked
);
  logic sel;

  always_comb begin
    sel = 1'b0;
    for (int b = 0; b < STAT_W; b++)
      if (32'(b) == LOCK_BASE + 32'(id)) sel = stat[b];
  end

  generate
    if (SYNC_N < 2) begin : g_one
      logic q;
      always_ff @(posedge clk)
        if (rst) q <= 1'b0;
        else     q <= sel;
      assign locked = q;
    end else begin : g_chain
      logic [SYNC_N-1:0] sh;
      always_ff @(posedge clk)
        if (rst) sh <= '0;
        else     sh <= {sh[SYNC_N-2:0], sel};
      assign locked = sh[SYNC_N-1];
    end
  endgenerate
endmodule

// File: rtl/seq_tick.sv
module seq_tick #(
  parameter int unsigned LIMIT = 240
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  assign hit = en && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk)
    if (rst || clr)     cnt <= '0;
    else if (en && !hit) cnt <= cnt + CW'(1);
endmodule

// File: rtl/pll_update_seq.sv
module pll_update_seq
  import pll_seq_pkg::*;
#(
  parameter int unsigned NR_W        = 6,
  parameter int unsigned NF_W        = 13,
  parameter int unsigned NO_W        = 4,
  parameter int unsigned BW_W        = 12,
  parameter int unsigned ID_W        = 3,
  parameter int unsigned NUM_PLL     = 5,
  parameter int unsigned LOCK_BASE   = 5,
  parameter int unsigned STAT_W      = 16,
  parameter int unsigned SYNC_N      = 2,
  parameter int unsigned REF_KHZ     = 24000,
  parameter int unsigned VCO_MIN_KHZ = 440000,
  parameter int unsigned VCO_MAX_KHZ = 2200000,
  parameter int unsigned OUT_MIN_KHZ = 27500,
  parameter int unsigned OUT_MAX_KHZ = 2200000,
  parameter int unsigned SETTLE_CYC  = 240,
  parameter int unsigned TIMEOUT_CYC = 100000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ID_W-1:0]   pll_id_i,
  input  logic [NR_W-1:0]   nr_i,
  input  logic [NF_W-1:0]   nf_i,
  input  logic [NO_W-1:0]   no_i,
  input  logic [STAT_W-1:0] lock_stat_i,
  output logic [1:0]        mode_o,
  output logic              pll_rst_o,
  output logic [ID_W-1:0]   tgt_id_o,
  output logic [NR_W-1:0]   nr_fld_o,
  output logic [NF_W-1:0]   nf_fld_o,
  output logic [NO_W-1:0]   no_fld_o,
  output logic [BW_W-1:0]   bw_fld_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [1:0]        fail_why_o
);
  seq_state_e      state_q;
  pll_mode_e       mode_q;
  logic [ID_W-1:0] id_q;
  logic [NR_W-1:0] nr_q;
  logic [NF_W-1:0] nf_q;
  logic [NO_W-1:0] no_q;
  logic [NF_W-1:0] half_m1;
  logic            cfg_ok, locked, settle_hit, to_hit;

  pll_cfg_check #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .ID_W(ID_W), .NUM_PLL(NUM_PLL),
    .REF_KHZ(REF_KHZ), .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ),
    .OUT_MIN_KHZ(OUT_MIN_KHZ), .OUT_MAX_KHZ(OUT_MAX_KHZ)
  ) u_check (
    .nr(nr_q), .nf(nf_q), .no(no_q), .id(id_q), .legal(cfg_ok)
  );

  pll_lock_pick #(
    .STAT_W(STAT_W), .LOCK_BASE(LOCK_BASE), .ID_W(ID_W), .SYNC_N(SYNC_N)
  ) u_lock (
    .clk(clk), .rst(rst), .stat(lock_stat_i), .id(id_q), .locked(locked)
  );

  seq_tick #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .clr(state_q != S_SETTLE), .en(state_q == S_SETTLE),
    .hit(settle_hit)
  );

  seq_tick #(.LIMIT(TIMEOUT_CYC)) u_timeout (
    .clk(clk), .rst(rst), .clr(state_q != S_POLL), .en(state_q == S_POLL),
    .hit(to_hit)
  );

  assign half_m1 = (nf_q >> 1) - NF_W'(1);
  assign mode_o  = mode_q;
  assign busy_o  = (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      mode_q     <= PM_SLOW;
      pll_rst_o  <= 1'b0;
      tgt_id_o   <= '0;
      nr_fld_o   <= '0;
      nf_fld_o   <= '0;
      no_fld_o   <= '0;
      bw_fld_o   <= '0;
      done_o     <= 1'b0;
      fail_o     <= 1'b0;
      fail_why_o <= WHY_NONE;
      id_q       <= '0;
      nr_q       <= '0;
      nf_q       <= '0;
      no_q       <= '0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          id_q    <= pll_id_i;
          nr_q    <= nr_i;
          nf_q    <= nf_i;
          no_q    <= no_i;
          state_q <= S_CHECK;
        end
        S_CHECK: begin
          if (!cfg_ok) begin
            fail_o     <= 1'b1;
            fail_why_o <= WHY_ILLEGAL;
            state_q    <= S_IDLE;
          end else begin
            mode_q   <= PM_SLOW;
            tgt_id_o <= id_q;
            state_q  <= S_ARM;
          end
        end
        S_ARM: begin
          pll_rst_o <= 1'b1;
          state_q   <= S_LOAD;
        end
        S_LOAD: begin
          nr_fld_o <= nr_q - NR_W'(1);
          nf_fld_o <= nf_q - NF_W'(1);
          no_fld_o <= no_q - NO_W'(1);
          bw_fld_o <= half_m1[BW_W-1:0];
          state_q  <= S_SETTLE;
        end
        S_SETTLE: if (settle_hit) begin
          pll_rst_o <= 1'b0;
          state_q   <= S_POLL;
        end
        S_POLL: begin
          if (locked) begin
            mode_q  <= PM_NORMAL;
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end else if (to_hit) begin
            fail_o     <= 1'b1;
            fail_why_o <= WHY_TIMEOUT;
            state_q    <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_update_seq_chk.sv
module pll_update_seq_chk #(
  parameter int unsigned NR_W       = 6,
  parameter int unsigned NF_W       = 13,
  parameter int unsigned NO_W       = 4,
  parameter int unsigned BW_W       = 12,
  parameter int unsigned SETTLE_CYC = 240
) (
  input logic            clk,
  input logic            rst,
  input logic [1:0]      mode_o,
  input logic            pll_rst_o,
  input logic [NR_W-1:0] nr_fld_o,
  input logic [NF_W-1:0] nf_fld_o,
  input logic [NO_W-1:0] no_fld_o,
  input logic [BW_W-1:0] bw_fld_o,
  input logic            done_o,
  input logic            fail_o,
  input logic [1:0]      fail_why_o
);
  localparam int unsigned HW = $clog2(SETTLE_CYC + 2) + 1;
  localparam int unsigned FW = NR_W + NF_W + NO_W + BW_W;

  logic [FW-1:0] flds, flds_prev;
  logic [HW-1:0] hold_cnt;

  assign flds = {nr_fld_o, nf_fld_o, no_fld_o, bw_fld_o};

  always_ff @(posedge clk) begin
    if (rst) begin
      flds_prev <= '0;
      hold_cnt  <= '0;
    end else begin
      flds_prev <= flds;
      if (!pll_rst_o || (flds != flds_prev)) hold_cnt <= '0;
      else if (hold_cnt != '1)               hold_cnt <= hold_cnt + HW'(1);
    end
  end

  // R7
  rst_in_slow_chk: assert property (@(posedge clk) disable iff (rst)
    pll_rst_o |-> (mode_o == 2'd0));

  // R8
  fields_under_rst_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(flds) |-> pll_rst_o);

  // R9
  settle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_rst_o) |-> (32'(hold_cnt) >= SETTLE_CYC - 1));

  // R10
  normal_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == 2'd1) && ($past(mode_o) != 2'd1)) |-> done_o);

  // R10
  done_fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && fail_o));

  // R6
  reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_o && (fail_why_o == 2'd1)) |-> ($stable(mode_o) && !pll_rst_o));

  // R11
  timeout_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_o && (fail_why_o == 2'd2)) |-> ((mode_o == 2'd0) && !pll_rst_o));
endmodule

bind pll_update_seq pll_update_seq_chk #(
  .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W), .SETTLE_CYC(SETTLE_CYC)
) u_chk (.*);

// File: tb/pll_update_seq_bench.sv
module pll_update_seq_bench;
  localparam int NR_W = 6, NF_W = 13, NO_W = 5, BW_W = 12, ID_W = 3;
  localparam int NUM_PLL = 5, LOCK_BASE = 5, STAT_W = 16;
  localparam int SETTLE = 6, TIMEOUT = 40, LOCK_DLY = 3;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [ID_W-1:0] pid = '0;
  logic [NR_W-1:0] nr = '0;
  logic [NF_W-1:0] nf = '0;
  logic [NO_W-1:0] no = '0;
  logic [STAT_W-1:0] lstat;
  logic [1:0] mode, why;
  logic prst, busy, done, fail;
  logic [ID_W-1:0] tgt;
  logic [NR_W-1:0] nrf;
  logic [NF_W-1:0] nff;
  logic [NO_W-1:0] nof;
  logic [BW_W-1:0] bwf;

  int total = 0, bad = 0;
  int cur_id = 0;
  logic dead = 1'b0;
  logic model_lock;
  int since;

  always #2 clk = ~clk;

  pll_update_seq #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W), .ID_W(ID_W),
    .NUM_PLL(NUM_PLL), .LOCK_BASE(LOCK_BASE), .STAT_W(STAT_W),
    .SETTLE_CYC(SETTLE), .TIMEOUT_CYC(TIMEOUT)
  ) u_pll_update_seq (
    .clk(clk), .rst(rst), .start_i(start), .pll_id_i(pid), .nr_i(nr),
    .nf_i(nf), .no_i(no), .lock_stat_i(lstat), .mode_o(mode),
    .pll_rst_o(prst), .tgt_id_o(tgt), .nr_fld_o(nrf), .nf_fld_o(nff),
    .no_fld_o(nof), .bw_fld_o(bwf), .busy_o(busy), .done_o(done),
    .fail_o(fail), .fail_why_o(why)
  );

  // PLL model: lock rises LOCK_DLY cycles after reset release
  always_ff @(posedge clk) begin
    if (rst || prst) begin
      since <= 0;
      model_lock <= 1'b0;
    end else if (!dead) begin
      if (since >= LOCK_DLY) model_lock <= 1'b1;
      else since <= since + 1;
    end
  end

  always_comb begin
    lstat = '1;
    for (int b = 0; b < STAT_W; b++)
      if (b == LOCK_BASE + cur_id) lstat[b] = model_lock;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int legal_class(int r, int f, int o, int id);
    real vco, outf;
    if (!(o == 1 || (o != 0 && o % 2 == 0))) return 2;
    if (r == 0 || id >= NUM_PLL) return 5;
    vco = 24000.0 * f / r;
    if (vco < 440000.0 || vco > 2200000.0) return 3;
    outf = vco / o;
    if (outf < 27500.0 || outf > 2200000.0) return 4;
    return 0;
  endfunction

  task automatic run_case(input int r, input int f, input int o, input int id);
    int cls, hold, rst_cyc, viol_slow, viol_fld, viol_lock, n;
    bit was_rst, got_done, got_fail;
    logic [1:0] m0, w;
    logic [NR_W-1:0] r0; logic [NF_W-1:0] f0; logic [NO_W-1:0] o0; logic [BW_W-1:0] b0;
    logic [NR_W-1:0] pr; logic [NF_W-1:0] pf; logic [NO_W-1:0] po; logic [BW_W-1:0] pb;
    string tag;
    cls = legal_class(r, f, o, id);
    tag = (cls == 2) ? "R2" : (cls == 3) ? "R3" : (cls == 4) ? "R4" :
          (cls == 5) ? "R5" : "R8";
    @(negedge clk);
    m0 = mode; r0 = nrf; f0 = nff; o0 = nof; b0 = bwf;
    pr = nrf; pf = nff; po = nof; pb = bwf;
    cur_id = id;
    pid = ID_W'(id); nr = NR_W'(r); nf = NF_W'(f); no = NO_W'(o); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    hold = 0; rst_cyc = 0; viol_slow = 0; viol_fld = 0; viol_lock = 0;
    was_rst = 1'b0; got_done = 1'b0; got_fail = 1'b0; w = 2'd0;
    for (n = 0; n < 400; n++) begin
      if (prst) begin
        rst_cyc++;
        if (mode != 2'd0) viol_slow++;
      end
      if ({nrf, nff, nof, bwf} != {pr, pf, po, pb}) begin
        if (!prst) viol_fld++;
        hold = 0;
      end
      if (prst) hold++;
      if (mode == 2'd1 && !model_lock) viol_lock++;
      pr = nrf; pf = nff; po = nof; pb = bwf;
      was_rst = prst;
      if (done || fail) begin
        got_done = done; got_fail = fail; w = why;
        break;
      end
      @(negedge clk);
    end
    check(got_done || got_fail, tag, "request completes", n, 400);
    if (cls != 0) begin
      check(got_fail && w == 2'd1, tag, "rejected as illegal", {got_fail, w}, 5);
      check(mode == m0 && rst_cyc == 0, "R6", "reject leaves mode/reset", rst_cyc, 0);
      check({nrf, nff, nof, bwf} == {r0, f0, o0, b0}, "R6", "reject keeps fields",
            nff, f0);
    end else if (dead) begin
      check(got_fail && w == 2'd2, "R11", "timeout reported", {got_fail, w}, 6);
      check(mode == 2'd0 && !prst, "R11", "timeout stays bypassed", mode, 0);
    end else begin
      check(got_done && mode == 2'd1, "R10", "done with normal mode",
            {got_done, mode}, 5);
      check(nrf == NR_W'(r - 1), "R8", "nr field", nrf, r - 1);
      check(nff == NF_W'(f - 1), "R8", "nf field", nff, f - 1);
      check(nof == NO_W'(o - 1), "R8", "no field", nof, o - 1);
      check(bwf == BW_W'((f >> 1) - 1), "R8", "bw field", bwf, (f >> 1) - 1);
      check(viol_fld == 0, "R8", "fields only change under reset", viol_fld, 0);
      check(viol_slow == 0, "R7", "slow while reset", viol_slow, 0);
      check(hold >= SETTLE && !prst, "R9", "reset hold after fields", hold, SETTLE);
      check(viol_lock == 0, "R10", "normal only after lock", viol_lock, 0);
      check(tgt == ID_W'(id), "R10", "target id", tgt, id);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(mode == 2'd0 && !prst, "R1", "mode/reset after reset", {mode, prst}, 0);
    check({nrf, nff, nof, bwf} == '0, "R1", "fields after reset", nff, 0);
    check(!busy && !done && !fail, "R1", "flags after reset", {busy, done, fail}, 0);

    // boundaries: VCO window (R3), output window (R4), NO rule (R2), misc (R5)
    run_case(1, 18, 1, 0);   // 432 MHz VCO: below
    run_case(1, 19, 1, 1);
    run_case(3, 55, 1, 2);   // exactly 440 MHz
    run_case(3, 275, 1, 3);  // exactly 2200 MHz
    run_case(3, 276, 1, 4);  // above
    run_case(1, 92, 1, 0);
    run_case(3, 55, 16, 1);  // exactly 27.5 MHz out
    run_case(1, 19, 16, 2);
    run_case(1, 19, 18, 3);  // 25.3 MHz out: below
    run_case(1, 40, 3, 0);   // odd NO
    run_case(1, 40, 0, 0);   // zero NO
    run_case(0, 40, 2, 0);   // zero NR
    run_case(1, 40, 2, 5);   // unknown PLL
    run_case(1, 40, 2, 7);

    // R11 lock never arrives, then recovery
    dead = 1'b1;
    run_case(2, 100, 2, 2);
    dead = 1'b0;
    run_case(2, 100, 2, 2);

    // R12 start while busy is ignored
    @(negedge clk);
    cur_id = 1;
    pid = 3'd1; nr = 6'd1; nf = 13'd50; no = 5'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    pid = 3'd1; nr = 6'd2; nf = 13'd120; no = 5'd4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 200 && !done && !fail; k++) @(negedge clk);
    check(done && nrf == 6'd0 && nff == 13'd49 && nof == 5'd1, "R12",
          "second start ignored", nff, 49);
    repeat (4) @(negedge clk);
    check(!busy, "R12", "no queued request", busy, 0);

    // sweep
    begin
      int idx = 0;
      for (int r = 1; r <= 4; r++)
        for (int f = 10; f <= 400; f += 13)
          for (int o = 0; o < 20; o++) begin
            run_case(r, f, o, idx % NUM_PLL);
            idx++;
          end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule